// File: doc/BRIEF.md
# Interrupt Message Vector Table with Unmask-Time Shadow Capture

This block is the device-side table of message-signalled interrupt vectors for a small function. Each vector owns four 32-bit words in an internal word-wide memory: two address halves, a data word, and a control word that holds the vector's mask. The host reaches the table through a plain word-addressed write and read port. A per-vector request input asks the block to signal an interrupt, and the block answers by presenting a 64-bit address and a 32-bit data word on a valid/ready output.

The message engine never builds a message from the live table. When software clears a vector's mask, the block copies that vector's address and data words, one memory read per cycle, into a shadow register set kept for that vector. Messages come only from this shadow set. A host update that spans several writes therefore cannot produce a message that mixes old and new fields, whatever order the writes arrive in and however closely they follow each other. Requests that arrive while a vector is blocked are remembered in a pending bit and delivered once the block is allowed to send them.

Top module: `msix_table_top`

## Requirements
- R1: The host port addresses 32-bit words. Word `4*v + k` belongs to vector `v`. Offset k=0 holds the low address, k=1 the high address, k=2 the data, and k=3 the control word, whose bit 0 is the mask. A read returns the stored word on `hostRdata` one cycle after `hostRe`.
- R2: After reset every control word reads 1 (masked) and every other word reads 0. `pendingBits` is 0 and `msgValid` is low.
- R3: No message for a vector is issued while its mask bit is 1. A request on that vector sets its bit in `pendingBits`.
- R4: A host write that changes a control word's bit 0 from 1 to 0 starts a capture of that vector's three address and data words, one word per cycle. If the vector is pending and the output is idle, `msgValid` rises exactly 5 clock edges after the edge that took the unmask write, and never earlier.
- R5: A message carries `msgAddr = {high, low}` and `msgData = data`, taken from the words as they stood at the most recent unmask of that vector.
- R6: A write to the address or data word of an unmasked vector changes what the host reads back, but it does not change the messages of that vector until its next unmask.
- R7: A pending, eligible vector issues exactly one message and its pending bit clears. Any number of requests made while it is pending merge into that single message.
- R8: While `funcMask` is 1, no message is issued for any vector. Requests set pending bits, and those bits are delivered after `funcMask` returns to 0.
- R9: Once `msgValid` is high, it stays high and `msgAddr` and `msgData` stay stable until a cycle in which `msgReady` is high.
- R10: When several vectors are eligible at the same time, they are issued in ascending vector-number order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host word write strobe |
| hostRe | input | 1 | Host word read strobe |
| hostWordAddr | input | 4 | Host word index into the table |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid one cycle after hostRe |
| irqReq | input | 4 | Per-vector interrupt request pulses |
| funcMask | input | 1 | Blocks all message issue when 1 |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Consumer accepts the message |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data |
| pendingBits | output | 4 | Per-vector pending flags |

## Verification
A read result is due one edge after the read strobe. A request on a masked vector shows in `pendingBits` one edge after its pulse. After an unmask write with a request already pending, `msgValid` is due at the fifth edge. The bench samples `msgValid` at the negative edges after edges one through four, where it must be low, and again after edge five, where it must be high. The bench drives every input and samples every output on falling edges. It records a handshake only when it sees valid and ready together at a falling edge, because that pair is taken at the next rising edge. Where a window must stay quiet, as with masked or globally blocked vectors, the bench counts a fixed number of cycles with ready high and then confirms that nothing was recorded and that the pending bit is still set.

// File: rtl/msix_pkg.sv
`timescale 1ns/1ps
package msix_pkg;
  localparam int VEC_IDX_W   = 2;
  localparam int NUM_VEC     = 1 << VEC_IDX_W;
  localparam int WORD_IDX_W  = VEC_IDX_W + 2;
  localparam int TBL_WORDS   = NUM_VEC * 4;
  localparam int DATA_W      = 32;
  localparam int CAP_WORDS   = 3;
  localparam logic [1:0] OFF_LO   = 2'd0;
  localparam logic [1:0] OFF_HI   = 2'd1;
  localparam logic [1:0] OFF_DATA = 2'd2;
  localparam logic [1:0] OFF_CTRL = 2'd3;

  typedef struct packed {
    logic                 capStart;
    logic                 capWe;
    logic                 capDone;
    logic [1:0]           capIdx;
    logic [VEC_IDX_W-1:0] capVec;
    logic                 issueLoad;
    logic [VEC_IDX_W-1:0] issueVec;
  } ctrlStrobes_t;

  function automatic logic [VEC_IDX_W-1:0] lowestSet(input logic [NUM_VEC-1:0] bits);
    logic [VEC_IDX_W-1:0] idx;
    idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (bits[i]) idx = VEC_IDX_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/msix_datapath.sv
`timescale 1ns/1ps
module msix_datapath
  import msix_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostWe,
  input  logic                  hostRe,
  input  logic [WORD_IDX_W-1:0] hostWordAddr,
  input  logic [DATA_W-1:0]     hostWdata,
  output logic [DATA_W-1:0]     hostRdata,
  input  logic [NUM_VEC-1:0]    irqReq,
  input  logic                  funcMask,
  input  logic                  msgReady,
  input  ctrlStrobes_t          strobes,
  output logic [NUM_VEC-1:0]    captureReq,
  output logic [NUM_VEC-1:0]    eligible,
  output logic [NUM_VEC-1:0]    maskVec,
  output logic [NUM_VEC-1:0]    shadowValid,
  output logic [NUM_VEC-1:0]    pendingBits,
  output logic                  msgValid,
  output logic [2*DATA_W-1:0]   msgAddr,
  output logic [DATA_W-1:0]     msgData
);
  logic [DATA_W-1:0] tableMem [TBL_WORDS];
  logic [DATA_W-1:0] shadowLo [NUM_VEC];
  logic [DATA_W-1:0] shadowHi [NUM_VEC];
  logic [DATA_W-1:0] shadowDt [NUM_VEC];

  logic [VEC_IDX_W-1:0]  hostVec;
  logic [1:0]            hostOff;
  logic [WORD_IDX_W-1:0] capWordIdx;
  logic [DATA_W-1:0]     capWord;
  logic                  ctrlWrite;

  assign hostVec    = hostWordAddr[WORD_IDX_W-1:2];
  assign hostOff    = hostWordAddr[1:0];
  assign ctrlWrite  = hostWe && (hostOff == OFF_CTRL);
  assign capWordIdx = {strobes.capVec, strobes.capIdx};
  assign capWord    = tableMem[capWordIdx];

  // Table storage and host read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_WORDS; i++)
        tableMem[i] <= ((i % 4) == 3) ? DATA_W'(1) : '0;
      hostRdata <= '0;
    end else begin
      if (hostWe) tableMem[hostWordAddr] <= hostWdata;
      if (hostRe) hostRdata <= tableMem[hostWordAddr];
    end
  end

  // Shadow capture, one word per cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        shadowLo[i] <= '0;
        shadowHi[i] <= '0;
        shadowDt[i] <= '0;
      end
    end else if (strobes.capWe) begin
      case (strobes.capIdx)
        OFF_LO:   shadowLo[strobes.capVec] <= capWord;
        OFF_HI:   shadowHi[strobes.capVec] <= capWord;
        OFF_DATA: shadowDt[strobes.capVec] <= capWord;
        default:  ;
      endcase
    end
  end

  // Per-vector mask, capture request, shadow valid and pending state
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic hit, unmaskEvt, maskEvt;
    assign maskVec[v] = tableMem[v*4 + 3][0];
    assign hit        = ctrlWrite && (hostVec == VEC_IDX_W'(v));
    assign unmaskEvt  = hit && maskVec[v] && !hostWdata[0];
    assign maskEvt    = hit && hostWdata[0];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        captureReq[v]  <= 1'b0;
        shadowValid[v] <= 1'b0;
        pendingBits[v] <= 1'b0;
      end else begin
        if (unmaskEvt)
          captureReq[v] <= 1'b1;
        else if (strobes.capStart && strobes.capVec == VEC_IDX_W'(v))
          captureReq[v] <= 1'b0;

        if (unmaskEvt || maskEvt)
          shadowValid[v] <= 1'b0;
        else if (strobes.capDone && strobes.capVec == VEC_IDX_W'(v)
                 && !maskVec[v] && !captureReq[v])
          shadowValid[v] <= 1'b1;

        if (irqReq[v])
          pendingBits[v] <= 1'b1;
        else if (strobes.issueLoad && strobes.issueVec == VEC_IDX_W'(v))
          pendingBits[v] <= 1'b0;
      end
    end
  end

  assign eligible = pendingBits & ~maskVec & shadowValid & {NUM_VEC{!funcMask}};

  // Message output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgAddr  <= '0;
      msgData  <= '0;
    end else if (strobes.issueLoad) begin
      msgValid <= 1'b1;
      msgAddr  <= {shadowHi[strobes.issueVec], shadowLo[strobes.issueVec]};
      msgData  <= shadowDt[strobes.issueVec];
    end else if (msgValid && msgReady) begin
      msgValid <= 1'b0;
    end
  end
endmodule

// File: rtl/msix_control.sv
`timescale 1ns/1ps
module msix_control
  import msix_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] captureReq,
  input  logic [NUM_VEC-1:0] eligible,
  input  logic               msgValid,
  output ctrlStrobes_t       strobes
);
  logic                 capBusy;
  logic [VEC_IDX_W-1:0] curVec;
  logic [1:0]           curIdx;

  always_comb begin
    strobes = '0;
    if (capBusy) begin
      strobes.capWe   = 1'b1;
      strobes.capVec  = curVec;
      strobes.capIdx  = curIdx;
      strobes.capDone = (curIdx == 2'(CAP_WORDS - 1));
    end else if (|captureReq) begin
      strobes.capStart = 1'b1;
      strobes.capVec   = lowestSet(captureReq);
    end
    if (!msgValid && |eligible) begin
      strobes.issueLoad = 1'b1;
      strobes.issueVec  = lowestSet(eligible);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capBusy <= 1'b0;
      curVec  <= '0;
      curIdx  <= '0;
    end else if (strobes.capStart) begin
      capBusy <= 1'b1;
      curVec  <= strobes.capVec;
      curIdx  <= '0;
    end else if (capBusy) begin
      if (strobes.capDone) capBusy <= 1'b0;
      else                 curIdx  <= curIdx + 2'd1;
    end
  end
endmodule

// File: rtl/msix_table_top.sv
`timescale 1ns/1ps
module msix_table_top
  import msix_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostWe,
  input  logic                  hostRe,
  input  logic [WORD_IDX_W-1:0] hostWordAddr,
  input  logic [DATA_W-1:0]     hostWdata,
  output logic [DATA_W-1:0]     hostRdata,
  input  logic [NUM_VEC-1:0]    irqReq,
  input  logic                  funcMask,
  output logic                  msgValid,
  input  logic                  msgReady,
  output logic [2*DATA_W-1:0]   msgAddr,
  output logic [DATA_W-1:0]     msgData,
  output logic [NUM_VEC-1:0]    pendingBits
);
  ctrlStrobes_t       strobes;
  logic [NUM_VEC-1:0] captureReq;
  logic [NUM_VEC-1:0] eligible;
  logic [NUM_VEC-1:0] maskVec;
  logic [NUM_VEC-1:0] shadowValid;

  msix_control u_ctrl (
    .clk(clk), .rstN(rstN), .captureReq(captureReq), .eligible(eligible),
    .msgValid(msgValid), .strobes(strobes)
  );

  msix_datapath u_dp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostRe(hostRe),
    .hostWordAddr(hostWordAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .irqReq(irqReq), .funcMask(funcMask), .msgReady(msgReady), .strobes(strobes),
    .captureReq(captureReq), .eligible(eligible), .maskVec(maskVec),
    .shadowValid(shadowValid), .pendingBits(pendingBits), .msgValid(msgValid),
    .msgAddr(msgAddr), .msgData(msgData)
  );
endmodule

// File: rtl/msix_checker.sv
`timescale 1ns/1ps
module msix_checker
  import msix_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                funcMask,
  input logic                msgValid,
  input logic                msgReady,
  input logic [2*DATA_W-1:0] msgAddr,
  input logic [DATA_W-1:0]   msgData,
  input ctrlStrobes_t        strobes,
  input logic [NUM_VEC-1:0]  maskVec,
  input logic [NUM_VEC-1:0]  pendingBits,
  input logic [NUM_VEC-1:0]  shadowValid
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));

  assert_no_issue_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueLoad |-> !maskVec[strobes.issueVec]);

  assert_no_issue_funcmask_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueLoad |-> !funcMask);

  assert_issue_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueLoad |-> pendingBits[strobes.issueVec]);

  assert_issue_from_shadow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueLoad |-> shadowValid[strobes.issueVec]);

  assert_capture_invalid_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capWe |-> !shadowValid[strobes.capVec]);
endmodule

bind msix_table_top msix_checker u_chk (
  .clk(clk), .rstN(rstN), .funcMask(funcMask), .msgValid(msgValid),
  .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData), .strobes(strobes),
  .maskVec(maskVec), .pendingBits(pendingBits), .shadowValid(shadowValid)
);

// File: tb/sim_msix_table_top.sv
`timescale 1ns/1ps
module sim_msix_table_top;
  import msix_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 1'b0, hostRe = 1'b0;
  logic [WORD_IDX_W-1:0] hostWordAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic [NUM_VEC-1:0] irqReq = '0;
  logic funcMask = 1'b0;
  logic msgValid, msgReady;
  logic [63:0] msgAddr;
  logic [31:0] msgData;
  logic [NUM_VEC-1:0] pendingBits;

  int checks = 0, fails = 0;
  int readyMode = 1;   // 0 hold low, 1 always high, 2 random
  bit finished = 1'b0;

  logic [31:0] tblLo [NUM_VEC], tblHi [NUM_VEC], tblDt [NUM_VEC];
  logic [31:0] shLo [NUM_VEC], shHi [NUM_VEC], shDt [NUM_VEC];
  logic [63:0] gotAddr [$];
  logic [31:0] gotData [$];

  always #2 clk = ~clk;  // 250 MHz

  msix_table_top u0 (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostRe(hostRe),
    .hostWordAddr(hostWordAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .irqReq(irqReq), .funcMask(funcMask), .msgValid(msgValid), .msgReady(msgReady),
    .msgAddr(msgAddr), .msgData(msgData), .pendingBits(pendingBits)
  );

  // Consumer: choose ready, record the handshake taken at the next rising edge
  initial msgReady = 1'b0;
  always @(negedge clk) begin
    if (readyMode == 0)      msgReady = 1'b0;
    else if (readyMode == 1) msgReady = 1'b1;
    else                     msgReady = 1'($urandom % 2);
    if (rstN && msgValid && msgReady) begin
      gotAddr.push_back(msgAddr);
      gotData.push_back(msgData);
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_IDX_W-1:0] wIdx(input int v, input int off);
    return WORD_IDX_W'(v * 4 + off);
  endfunction

  task automatic hostWrite(input logic [WORD_IDX_W-1:0] a, input logic [31:0] d);
    hostWe = 1'b1; hostWordAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [WORD_IDX_W-1:0] a, output logic [31:0] d);
    hostRe = 1'b1; hostWordAddr = a;
    @(negedge clk);
    hostRe = 1'b0;
    d = hostRdata;
  endtask

  task automatic pulseIrq(input logic [NUM_VEC-1:0] m);
    irqReq = m;
    @(negedge clk);
    irqReq = '0;
  endtask

  task automatic unmaskVec(input int v);
    hostWrite(wIdx(v, 3), 32'd0);
    shLo[v] = tblLo[v]; shHi[v] = tblHi[v]; shDt[v] = tblDt[v];
  endtask

  task automatic programVec(input int v, input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] dt);
    hostWrite(wIdx(v, 3), 32'd1);
    hostWrite(wIdx(v, 0), lo); tblLo[v] = lo;
    hostWrite(wIdx(v, 1), hi); tblHi[v] = hi;
    hostWrite(wIdx(v, 2), dt); tblDt[v] = dt;
    unmaskVec(v);
    repeat (6) @(negedge clk);
  endtask

  task automatic waitMsgs(input int n);
    for (int i = 0; i < 300 && gotAddr.size() < n; i++) @(negedge clk);
  endtask

  task automatic expectMsg(input int v, input string req);
    logic [63:0] a; logic [31:0] d;
    if (gotAddr.size() == 0) begin
      check(1'b0, req, 64'd0, 64'd1);
      return;
    end
    a = gotAddr.pop_front(); d = gotData.pop_front();
    check(a == {shHi[v], shLo[v]}, req, a, {shHi[v], shLo[v]});
    check(d == shDt[v], req, {32'd0, d}, {32'd0, shDt[v]});
  endtask

  task automatic clearQ();
    gotAddr.delete(); gotData.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] heldA;
    void'($urandom(32'd20230410));
    for (int v = 0; v < NUM_VEC; v++) begin
      tblLo[v] = 0; tblHi[v] = 0; tblDt[v] = 0; shLo[v] = 0; shHi[v] = 0; shDt[v] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2: reset state
    check(msgValid == 1'b0, "R2 valid", 64'(msgValid), 64'd0);
    check(pendingBits == '0, "R2 pending", 64'(pendingBits), 64'd0);
    for (int v = 0; v < NUM_VEC; v++) begin
      hostRead(wIdx(v, 3), rd);
      check(rd == 32'd1, "R2 ctrl reset", 64'(rd), 64'd1);
      hostRead(wIdx(v, 1), rd);
      check(rd == 32'd0, "R2 addr reset", 64'(rd), 64'd0);
    end

    // R1: word layout readback
    hostWrite(wIdx(2, 0), 32'hA0A0_0001); tblLo[2] = 32'hA0A0_0001;
    hostWrite(wIdx(2, 2), 32'hD0D0_0002); tblDt[2] = 32'hD0D0_0002;
    hostRead(wIdx(2, 0), rd);
    check(rd == 32'hA0A0_0001, "R1 low word", 64'(rd), 64'hA0A0_0001);
    hostRead(wIdx(2, 2), rd);
    check(rd == 32'hD0D0_0002, "R1 data word", 64'(rd), 64'hD0D0_0002);

    // R3: request on masked vector 0 only pends
    clearQ();
    pulseIrq(4'b0001);
    check(pendingBits[0] == 1'b1, "R3 pending set", 64'(pendingBits), 64'd1);
    repeat (20) @(negedge clk);
    check(gotAddr.size() == 0 && !msgValid, "R3 no message", 64'(gotAddr.size()), 64'd0);

    // R4: unmask latency, R5 payload, R9 hold
    readyMode = 0;
    hostWrite(wIdx(0, 0), 32'h1111_0000); tblLo[0] = 32'h1111_0000;
    hostWrite(wIdx(0, 1), 32'h2222_0000); tblHi[0] = 32'h2222_0000;
    hostWrite(wIdx(0, 2), 32'h3333_0000); tblDt[0] = 32'h3333_0000;
    unmaskVec(0);
    repeat (4) @(negedge clk);
    check(msgValid == 1'b0, "R4 not early", 64'(msgValid), 64'd0);
    @(negedge clk);
    check(msgValid == 1'b1, "R4 on time", 64'(msgValid), 64'd1);
    check(msgAddr == 64'h2222_0000_1111_0000, "R5 address", msgAddr, 64'h2222_0000_1111_0000);
    check(msgData == 32'h3333_0000, "R5 data", 64'(msgData), 64'h3333_0000);
    heldA = msgAddr;
    repeat (10) @(negedge clk);
    check(msgValid && msgAddr == heldA, "R9 held", msgAddr, heldA);
    readyMode = 1;
    waitMsgs(1);
    repeat (5) @(negedge clk);
    check(gotAddr.size() == 1, "R7 exactly one", 64'(gotAddr.size()), 64'd1);
    check(pendingBits[0] == 1'b0, "R7 pending cleared", 64'(pendingBits), 64'd0);
    clearQ();

    // R6: live update of unmasked entry
    hostWrite(wIdx(0, 0), 32'h5555_AAAA); tblLo[0] = 32'h5555_AAAA;
    hostRead(wIdx(0, 0), rd);
    check(rd == 32'h5555_AAAA, "R6 table updated", 64'(rd), 64'h5555_AAAA);
    pulseIrq(4'b0001);
    waitMsgs(1);
    expectMsg(0, "R6 shadow kept");

    // R8: function mask
    clearQ();
    funcMask = 1'b1;
    pulseIrq(4'b0001);
    repeat (20) @(negedge clk);
    check(gotAddr.size() == 0, "R8 blocked", 64'(gotAddr.size()), 64'd0);
    check(pendingBits[0] == 1'b1, "R8 pending kept", 64'(pendingBits), 64'd1);
    funcMask = 1'b0;
    waitMsgs(1);
    repeat (5) @(negedge clk);
    check(gotAddr.size() == 1, "R8 delivered once", 64'(gotAddr.size()), 64'd1);
    expectMsg(0, "R8 payload");

    // R10: ascending order across all vectors
    for (int v = 1; v < NUM_VEC; v++)
      programVec(v, 32'h0100_0000 * v, 32'h0000_0F00 + v, 32'hC0DE_0000 + v);
    clearQ();
    readyMode = 0;
    pulseIrq('1);
    repeat (10) @(negedge clk);
    readyMode = 1;
    waitMsgs(NUM_VEC);
    for (int v = 0; v < NUM_VEC; v++) expectMsg(v, "R10 order");

    // R7: coalescing and R5 torn-update immunity on vector 2
    clearQ();
    hostWrite(wIdx(2, 3), 32'd1);
    pulseIrq(4'b0100);
    hostWrite(wIdx(2, 0), 32'hBEEF_0002); tblLo[2] = 32'hBEEF_0002;
    pulseIrq(4'b0100);
    pulseIrq(4'b0100);
    repeat (10) @(negedge clk);
    check(gotAddr.size() == 0, "R3 masked during update", 64'(gotAddr.size()), 64'd0);
    unmaskVec(2);
    waitMsgs(1);
    repeat (10) @(negedge clk);
    check(gotAddr.size() == 1, "R7 coalesced", 64'(gotAddr.size()), 64'd1);
    expectMsg(2, "R5 new low old high");

    // Random: R5 and R10 under random ready
    readyMode = 2;
    for (int it = 0; it < 40; it++) begin
      int v;
      logic [NUM_VEC-1:0] m;
      v = int'($urandom % NUM_VEC);
      programVec(v, $urandom, $urandom, $urandom);
      m = NUM_VEC'($urandom);
      clearQ();
      pulseIrq(m);
      waitMsgs($countones(m));
      repeat (3) @(negedge clk);
      check(gotAddr.size() == $countones(m), "R7 random count", 64'(gotAddr.size()), 64'($countones(m)));
      for (int k = 0; k < NUM_VEC; k++)
        if (m[k]) expectMsg(k, "R10 random order");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule